// File: doc/BRIEF.md
# LIN Controller Operating-Mode and Configuration Register

This block holds the control word of a LIN serial controller and runs the controller's operating-mode state machine. The three modes are Initialization, Normal and Sleep. Software writes and reads the control word over a simple register port. The mode follows two request bits, one for init and one for sleep. A wakeup status input lets hardware drop the sleep request when auto-wakeup is enabled.

The configuration bits select master or slave operation, loop back, self test, the slave break threshold, the receive-buffer lock and filter bypass. Software can change them only while the block is in Initialization mode. The block drives these bits as outputs.

The block also contains a one-message slave receive holder. While the block is in Normal mode, the holder accepts messages whose identifier matched a filter. With filter bypass set, it also accepts messages whose identifier matched no filter. When a new message arrives while the holder is full, the lock bit decides the outcome: the new message overwrites the stored one, or the new message is discarded.

Top module: `lin_mode_ctrl`

## Requirements
- R1: After reset, `mode` is Initialization (2'b01) and `rd_data` reads 9'h001, meaning only the init request (bit 0) is set. The receive holder is empty and all pulse outputs are low.
- R2: Mode encodings are Normal = 2'b10, Initialization = 2'b01 and Sleep = 2'b11. One cycle after the control word changes, `mode` shows the new mode. Bit 0 set selects Initialization. Bit 0 clear with bit 1 set selects Sleep. Bit 0 and bit 1 both clear select Normal.
- R3: When init (bit 0) and sleep (bit 1) are both set, the mode is Initialization.
- R4: Control bits 8..3 change on a write only while `mode` is Initialization. Their layout is bit 3 master, bit 4 loop back, bit 5 self test, bit 6 break threshold, bit 7 receive lock and bit 8 filter bypass. In the other modes these bits keep their value silently, and `rd_data` returns the kept value. Bits 2..0 can be written in any mode. Bit 2 is the auto-wakeup enable.
- R5: When bit 2 is set and `wake_flag` is high at a clock edge, bit 1 is cleared at that edge. This clear wins over a write at the same edge that sets bit 1.
- R6: `brk_len` is 11 when bit 6 is 0 and 10 when bit 6 is 1.
- R7: A message on `rx_valid` is accepted only in Normal mode, and only when `rx_hit` is high or bit 8 is set. Each acceptance gives a one-cycle `rx_irq` pulse in the cycle after the message. A message that is not accepted has no effect.
- R8: With bit 7 clear, an accepted message that finds the holder full replaces the stored message. This raises `rx_irq` and `rx_ovwr` for one cycle.
- R9: With bit 7 set, an accepted message that finds the holder full is discarded. The stored message is kept, `rx_drop` pulses for one cycle and `rx_irq` stays low.
- R10: `rx_pop` empties the holder. When a pop and an accepted message fall on the same edge, the new message is stored as into an empty holder, with no overwrite and no drop.
- R11: `master_en`, `loopback`, `self_test`, `rx_lock` and `filt_bypass` drive the values of control bits 3, 4, 5, 7 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 9 | Control word write value |
| rd_data | output | 9 | Current control word |
| wake_flag | input | 1 | Wakeup detected status |
| mode | output | 2 | Current operating mode |
| master_en | output | 1 | Master (1) or slave (0) operation |
| loopback | output | 1 | Loop back enable |
| self_test | output | 1 | Self test enable |
| brk_len | output | 4 | Slave break detection length in bits |
| rx_lock | output | 1 | Receive holder locked against overrun |
| filt_bypass | output | 1 | Accept identifiers that match no filter |
| rx_valid | input | 1 | Received message present |
| rx_hit | input | 1 | Message identifier matched a filter |
| rx_msg | input | MSG_W | Received message payload |
| rx_pop | input | 1 | Software has read the holder |
| buf_full | output | 1 | Holder contains a message |
| buf_msg | output | MSG_W | Stored message |
| rx_irq | output | 1 | Message stored (one-cycle pulse) |
| rx_ovwr | output | 1 | Stored message was overwritten (pulse) |
| rx_drop | output | 1 | New message discarded by the lock (pulse) |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a software write that sets the sleep request and a hardware wakeup clear. The second pair is a pop and a new arrival in the receive holder. Directed steps put each pair on one edge. The first pair is judged by the sleep bit read back. The second pair is judged by the holder contents and by the absence of `rx_ovwr` and `rx_drop`. Random stimulus from a fixed seed also produces both pairs. Every cycle is compared against a bench model built from the requirements.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;
  typedef enum logic [1:0] {
    MODE_INIT   = 2'b01,
    MODE_NORMAL = 2'b10,
    MODE_SLEEP  = 2'b11
  } lin_mode_e;

  localparam int CTRL_W   = 9;
  localparam int B_INIT   = 0;
  localparam int B_SLEEP  = 1;
  localparam int B_AWAKE  = 2;
  localparam int B_MASTER = 3;
  localparam int B_LOOP   = 4;
  localparam int B_STEST  = 5;
  localparam int B_BRK10  = 6;
  localparam int B_RXLOCK = 7;
  localparam int B_BYPASS = 8;
  localparam int LOCK_LO  = 3;

  localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(1) << B_INIT;
endpackage

// File: rtl/lin_ctrl_reg.sv
module lin_ctrl_reg
  import lin_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              cfg_open,
  input  logic              wake_flag,
  output logic [CTRL_W-1:0] ctrl_q
);
  logic [CTRL_W-1:0] ctrl_d;
  logic [CTRL_W-1:0] bit_we;
  logic              hw_wake_clr;

  assign hw_wake_clr = ctrl_q[B_AWAKE] & wake_flag;

  // per-bit write enable: low bits always, configuration bits only when open
  for (genvar i = 0; i < CTRL_W; i++) begin : g_we
    if (i < LOCK_LO) begin : g_free
      assign bit_we[i] = wr_en;
    end else begin : g_locked
      assign bit_we[i] = wr_en & cfg_open;
    end
  end

  always_comb begin
    for (int i = 0; i < CTRL_W; i++) begin
      ctrl_d[i] = bit_we[i] ? wr_data[i] : ctrl_q[i];
    end
    if (hw_wake_clr) begin
      ctrl_d[B_SLEEP] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end
endmodule

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm
  import lin_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      init_req,
  input  logic      sleep_req,
  output lin_mode_e mode_q
);
  lin_mode_e mode_d;

  always_comb begin
    if (init_req) begin
      mode_d = MODE_INIT;
    end else if (sleep_req) begin
      mode_d = MODE_SLEEP;
    end else begin
      mode_d = MODE_NORMAL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_INIT;
    end else begin
      mode_q <= mode_d;
    end
  end
endmodule

// File: rtl/lin_rx_hold.sv
module lin_rx_hold #(
  parameter int MSG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_open,
  input  logic             rx_valid,
  input  logic             rx_hit,
  input  logic             bypass,
  input  logic             lock,
  input  logic [MSG_W-1:0] rx_msg,
  input  logic             rx_pop,
  output logic             buf_full,
  output logic [MSG_W-1:0] buf_msg,
  output logic             irq_q,
  output logic             ovwr_q,
  output logic             drop_q
);
  logic accept, room, store;
  logic full_d, irq_d, ovwr_d, drop_d;

  assign accept = rx_open & rx_valid & (rx_hit | bypass);
  assign room   = ~buf_full | rx_pop;

  always_comb begin
    store  = 1'b0;
    irq_d  = 1'b0;
    ovwr_d = 1'b0;
    drop_d = 1'b0;
    full_d = buf_full & ~rx_pop;
    if (accept) begin
      if (room) begin
        store = 1'b1;
      end else if (!lock) begin
        store  = 1'b1;
        ovwr_d = 1'b1;
      end else begin
        drop_d = 1'b1;
      end
      irq_d = store;
      if (store) begin
        full_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_full <= 1'b0;
      irq_q    <= 1'b0;
      ovwr_q   <= 1'b0;
      drop_q   <= 1'b0;
    end else begin
      buf_full <= full_d;
      irq_q    <= irq_d;
      ovwr_q   <= ovwr_d;
      drop_q   <= drop_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_msg <= '0;
    end else if (store) begin
      buf_msg <= rx_msg;
    end
  end
endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
  import lin_mode_pkg::*;
#(
  parameter int MSG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [8:0]       wr_data,
  output logic [8:0]       rd_data,
  input  logic             wake_flag,
  output logic [1:0]       mode,
  output logic             master_en,
  output logic             loopback,
  output logic             self_test,
  output logic [3:0]       brk_len,
  output logic             rx_lock,
  output logic             filt_bypass,
  input  logic             rx_valid,
  input  logic             rx_hit,
  input  logic [MSG_W-1:0] rx_msg,
  input  logic             rx_pop,
  output logic             buf_full,
  output logic [MSG_W-1:0] buf_msg,
  output logic             rx_irq,
  output logic             rx_ovwr,
  output logic             rx_drop
);
  localparam logic [3:0] BRK_LONG  = 4'd11;
  localparam logic [3:0] BRK_SHORT = 4'd10;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [CTRL_W-1:0] ctrl_q;
  lin_mode_e         mode_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  lin_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .cfg_open (mode_q == MODE_INIT),
    .wake_flag(wake_flag),
    .ctrl_q   (ctrl_q)
  );

  lin_mode_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .init_req (ctrl_q[B_INIT]),
    .sleep_req(ctrl_q[B_SLEEP]),
    .mode_q   (mode_q)
  );

  lin_rx_hold #(.MSG_W(MSG_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .rx_open (mode_q == MODE_NORMAL),
    .rx_valid(rx_valid),
    .rx_hit  (rx_hit),
    .bypass  (ctrl_q[B_BYPASS]),
    .lock    (ctrl_q[B_RXLOCK]),
    .rx_msg  (rx_msg),
    .rx_pop  (rx_pop),
    .buf_full(buf_full),
    .buf_msg (buf_msg),
    .irq_q   (rx_irq),
    .ovwr_q  (rx_ovwr),
    .drop_q  (rx_drop)
  );

  assign rd_data     = ctrl_q;
  assign mode        = mode_q;
  assign master_en   = ctrl_q[B_MASTER];
  assign loopback    = ctrl_q[B_LOOP];
  assign self_test   = ctrl_q[B_STEST];
  assign rx_lock     = ctrl_q[B_RXLOCK];
  assign filt_bypass = ctrl_q[B_BYPASS];
  assign brk_len     = ctrl_q[B_BRK10] ? BRK_SHORT : BRK_LONG;
endmodule

// File: rtl/lin_mode_ctrl_chk.sv
module lin_mode_ctrl_chk
  import lin_mode_pkg::*;
#(
  parameter int MSG_W = 16
) (
  input logic             clk,
  input logic             rst_int_n,
  input logic [8:0]       rd_data,
  input logic             wake_flag,
  input logic [1:0]       mode,
  input logic             buf_full,
  input logic [MSG_W-1:0] buf_msg,
  input logic             rx_irq,
  input logic             rx_ovwr,
  input logic             rx_drop
);
  // R3
  init_wins_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_data[B_INIT] |=> mode == MODE_INIT);

  // R2
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!rd_data[B_INIT] && rd_data[B_SLEEP]) |=> mode == MODE_SLEEP);

  // R4
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode != MODE_INIT) |=> $stable(rd_data[8:3]));

  // R5
  wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_data[B_AWAKE] && wake_flag) |=> !rd_data[B_SLEEP]);

  // R7
  rx_closed_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode != MODE_NORMAL) |=> (!rx_irq && !rx_ovwr && !rx_drop));

  // R7
  irq_full_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rx_irq |-> buf_full);

  // R8
  ovwr_irq_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rx_ovwr |-> (rx_irq && !rx_drop));

  // R9
  drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rx_drop |-> (buf_full && $stable(buf_msg) && !rx_irq));
endmodule

bind lin_mode_ctrl lin_mode_ctrl_chk #(.MSG_W(MSG_W)) u_chk (
  .clk      (clk),
  .rst_int_n(rst_int_n),
  .rd_data  (rd_data),
  .wake_flag(wake_flag),
  .mode     (mode),
  .buf_full (buf_full),
  .buf_msg  (buf_msg),
  .rx_irq   (rx_irq),
  .rx_ovwr  (rx_ovwr),
  .rx_drop  (rx_drop)
);

// File: tb/lin_mode_ctrl_tb.sv
`timescale 1ns/1ps
module lin_mode_ctrl_tb;
  localparam int MW = 16;
  localparam logic [1:0] M_INIT = 2'b01, M_NORM = 2'b10, M_SLP = 2'b11;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, wake_flag, rx_valid, rx_hit, rx_pop;
  logic [8:0] wr_data, rd_data;
  logic [1:0] mode;
  logic master_en, loopback, self_test, rx_lock, filt_bypass;
  logic [3:0] brk_len;
  logic [MW-1:0] rx_msg, buf_msg;
  logic buf_full, rx_irq, rx_ovwr, rx_drop;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model
  logic [8:0]    e_ctrl;
  logic [1:0]    e_mode;
  logic          e_full, e_irq, e_ovwr, e_drop;
  logic [MW-1:0] e_msg;

  always #2.5 clk = ~clk;

  lin_mode_ctrl #(.MSG_W(MW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .wake_flag(wake_flag), .mode(mode), .master_en(master_en), .loopback(loopback),
    .self_test(self_test), .brk_len(brk_len), .rx_lock(rx_lock), .filt_bypass(filt_bypass),
    .rx_valid(rx_valid), .rx_hit(rx_hit), .rx_msg(rx_msg), .rx_pop(rx_pop),
    .buf_full(buf_full), .buf_msg(buf_msg), .rx_irq(rx_irq), .rx_ovwr(rx_ovwr),
    .rx_drop(rx_drop)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] mode_of(input logic [8:0] c);
    if (c[0]) return M_INIT;
    if (c[1]) return M_SLP;
    return M_NORM;
  endfunction

  function automatic logic [3:0] brk_of(input logic b);
    return b ? 4'd10 : 4'd11;
  endfunction

  task automatic check_all();
    chk("R2 mode", {30'd0, mode}, {30'd0, e_mode});
    chk("R4 rd_data", {23'd0, rd_data}, {23'd0, e_ctrl});
    chk("R6 brk_len", {28'd0, brk_len}, {28'd0, brk_of(e_ctrl[6])});
    chk("R11 cfg", {27'd0, master_en, loopback, self_test, rx_lock, filt_bypass},
        {27'd0, e_ctrl[3], e_ctrl[4], e_ctrl[5], e_ctrl[7], e_ctrl[8]});
    chk("R10 buf_full", {31'd0, buf_full}, {31'd0, e_full});
    if (e_full) chk("R8 buf_msg", {16'd0, buf_msg}, {16'd0, e_msg});
    chk("R7 rx_irq", {31'd0, rx_irq}, {31'd0, e_irq});
    chk("R8 rx_ovwr", {31'd0, rx_ovwr}, {31'd0, e_ovwr});
    chk("R9 rx_drop", {31'd0, rx_drop}, {31'd0, e_drop});
  endtask

  task automatic step(input logic wr, input logic [8:0] wd, input logic wk,
                      input logic rv, input logic ht, input logic [MW-1:0] m,
                      input logic pp);
    logic [8:0] n_ctrl;
    logic [1:0] n_mode;
    logic acc;
    @(negedge clk);
    wr_en = wr; wr_data = wd; wake_flag = wk;
    rx_valid = rv; rx_hit = ht; rx_msg = m; rx_pop = pp;
    n_ctrl = e_ctrl;
    if (wr) begin
      n_ctrl[2:0] = wd[2:0];
      if (e_mode == M_INIT) n_ctrl[8:3] = wd[8:3];
    end
    if (e_ctrl[2] && wk) n_ctrl[1] = 1'b0;
    n_mode = mode_of(e_ctrl);
    acc = rv && (e_mode == M_NORM) && (ht || e_ctrl[8]);
    e_irq = 0; e_ovwr = 0; e_drop = 0;
    if (acc) begin
      if (!e_full || pp) begin
        e_full = 1; e_msg = m; e_irq = 1;
      end else if (!e_ctrl[7]) begin
        e_msg = m; e_irq = 1; e_ovwr = 1;
      end else begin
        e_drop = 1;
      end
    end else if (pp) begin
      e_full = 0;
    end
    @(posedge clk);
    #1;
    e_ctrl = n_ctrl;
    e_mode = n_mode;
    check_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 9'h0, 0, 0, 0, '0, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; wr_en = 0; wr_data = 0; wake_flag = 0;
    rx_valid = 0; rx_hit = 0; rx_msg = 0; rx_pop = 0;
    e_ctrl = 9'h001; e_mode = M_INIT; e_full = 0; e_msg = 0;
    e_irq = 0; e_ovwr = 0; e_drop = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 mode", {30'd0, mode}, {30'd0, M_INIT});
    chk("R1 rd_data", {23'd0, rd_data}, 32'h001);
    chk("R1 buf_full", {31'd0, buf_full}, 32'd0);
    chk("R1 pulses", {29'd0, rx_irq, rx_ovwr, rx_drop}, 32'd0);

    // R4: configure all in INIT, then leave to Normal
    step(1, 9'b1_1111_1001, 0, 0, 0, '0, 0);
    step(1, 9'b1_1111_1000, 0, 0, 0, '0, 0);
    idle(1);
    chk("R2 normal", {30'd0, mode}, {30'd0, M_NORM});
    step(1, 9'b0_0000_0000, 0, 0, 0, '0, 0);
    chk("R4 locked kept", {26'd0, rd_data[8:3]}, 32'h3F);

    // R9: lock set, second message discarded
    step(0, 9'h0, 0, 1, 1, 16'hA5A5, 0);
    step(0, 9'h0, 0, 1, 1, 16'h5A5A, 0);
    chk("R9 drop", {31'd0, rx_drop}, 32'd1);
    chk("R9 kept msg", {16'd0, buf_msg}, 32'hA5A5);
    // R10: pop and arrival in the same edge
    step(0, 9'h0, 0, 1, 0, 16'h1234, 1);
    chk("R10 same-edge", {16'd0, buf_msg}, 32'h1234);
    chk("R10 no ovwr/drop", {30'd0, rx_ovwr, rx_drop}, 32'd0);
    step(0, 9'h0, 0, 0, 0, '0, 1);

    // R3: init and sleep together
    step(1, 9'b0_0000_0011, 0, 0, 0, '0, 0);
    idle(1);
    chk("R3 init wins", {30'd0, mode}, {30'd0, M_INIT});
    // unlock, no bypass, awake enabled, go to Sleep
    step(1, 9'b0_0000_0111, 0, 0, 0, '0, 0);
    step(1, 9'b0_0000_0110, 0, 0, 0, '0, 0);
    idle(1);
    chk("R2 sleep", {30'd0, mode}, {30'd0, M_SLP});
    chk("R6 brk 11", {28'd0, brk_len}, 32'd11);
    // R7: message ignored in Sleep
    step(0, 9'h0, 0, 1, 1, 16'hBEEF, 0);
    chk("R7 sleep ignore", {31'd0, buf_full}, 32'd0);
    // R5: wakeup clear beats a simultaneous sleep write
    step(1, 9'b0_0000_0110, 1, 0, 0, '0, 0);
    chk("R5 wake clear", {31'd0, rd_data[1]}, 32'd0);
    idle(1);
    chk("R5 to normal", {30'd0, mode}, {30'd0, M_NORM});
    // R7: unmatched without bypass ignored; R8 overwrite
    step(0, 9'h0, 0, 1, 0, 16'h0F0F, 0);
    chk("R7 unmatched", {31'd0, rx_irq}, 32'd0);
    step(0, 9'h0, 0, 1, 1, 16'h1111, 0);
    step(0, 9'h0, 0, 1, 1, 16'h2222, 0);
    chk("R8 ovwr", {31'd0, rx_ovwr}, 32'd1);
    chk("R8 new msg", {16'd0, buf_msg}, 32'h2222);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [8:0] wd;
      wd = 9'($urandom);
      wd[0] = ($urandom % 3) == 0;
      wd[1] = ($urandom % 4) == 0;
      step(($urandom % 4) == 0, wd, ($urandom % 6) == 0, ($urandom % 3) == 0,
           ($urandom % 2) == 0, 16'($urandom), ($urandom % 5) == 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule